// File: doc/BRIEF.md
# GPIO Interrupt Detection Controller

This block watches one bank of general-purpose input pins and records interrupt events on them. Each pin has three configuration bits: one picks level or edge sensitivity, one picks the active level or edge direction, and one, for edge pins only, makes the pin fire on both edges. A detected event sets that pin's pending bit. The pending bit stays set until software writes a one to it.

Interrupt enables are never written as a whole word. A write-one-to-set port turns enables on and a write-one-to-clear port turns them off, so concurrent agents never race on a read-modify-write. The single interrupt output is raised while any pin is both pending and enabled. Pin inputs are asynchronous and pass through a two-stage synchroniser before detection.

Register access is a flat strobe interface: one write strobe with a 3-bit select and a data word, and a combinational read port with its own select.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: A write with select 0 sets the enable of every pin whose data bit is 1. Pins whose data bit is 0 keep their enable.
- R2: A write with select 1 clears the enable of every pin whose data bit is 1. Pins whose data bit is 0 keep their enable.
- R3: A read with select 0 or 1 returns the enable word, with bit k = 1 when pin k is enabled.
- R4: A write with select 2 clears every pending bit whose data bit is 1 and leaves the other pending bits untouched. A read with select 2 returns the pending word.
- R5: A pin whose type bit is 0 is level sensitive. A polarity bit of 0 means active low and 1 means active high. The pending bit is set on every cycle the synchronised input sits at the active level, including the cycle just after a clear.
- R6: A pin whose type bit is 1 and any-edge bit is 0 fires only on a rising edge when its polarity bit is 1, and only on a falling edge when its polarity bit is 0.
- R7: A pin whose type bit is 1 and any-edge bit is 1 fires on both edges, whatever its polarity bit.
- R8: Selects 3, 4 and 5 are the type, polarity and any-edge words. A write replaces all bits and a read returns the stored word. Selects 6 and 7 read as zero and their writes change nothing.
- R9: When an event and a clear of the same pending bit fall in the same cycle, the bit ends up set.
- R10: irq_o is 1 exactly when some pin is both pending and enabled.
- R11: During reset every register is zero, so all pins are disabled, level sensitive and active low, and irq_o is 0.
- R12: A pin change is first visible in the pending word after the third rising clock edge that follows it, because of the two synchroniser stages and the registered pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | N_PINS | Asynchronous GPIO pin levels |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Write register select |
| wr_data_i | input | N_PINS | Write data word |
| rd_sel_i | input | 3 | Read register select |
| rd_data_o | output | N_PINS | Read data for rd_sel_i (combinational) |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the controller with N_PINS = 4. This width makes it possible to walk every pair of start and end pin vectors (256 transitions) under all eight per-pin modes. The modes are rotated so that every pin meets every combination of type, polarity and any-edge setting. At this width the expected pending word, enable word and interrupt level can also be computed bit by bit for every transition. Directed sequences then pin down the cycle on which an event and a clear collide, and the exact synchroniser latency.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    typedef enum logic [2:0] {
        SEL_EN_SET = 3'd0,
        SEL_EN_CLR = 3'd1,
        SEL_STATUS = 3'd2,
        SEL_TYPE   = 3'd3,
        SEL_POL    = 3'd4,
        SEL_ANY    = 3'd5
    } reg_sel_e;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] cur_o,
    output logic [W-1:0] prev_o
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] cur;
        logic [W-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = pin_i;
        st_d.cur  = st_q.meta;
        st_d.prev = st_q.cur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur_o  = st_q.cur;
    assign prev_o = st_q.prev;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] type_i,
    input  logic [W-1:0] pol_i,
    input  logic [W-1:0] any_i,
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] prev_i,
    output logic [W-1:0] evt_o
);
    for (genvar k = 0; k < W; k++) begin : g_pin
        logic rise, fall, lvl_hit, edge_hit;
        assign rise     = cur_i[k] & ~prev_i[k];
        assign fall     = ~cur_i[k] & prev_i[k];
        assign lvl_hit  = (cur_i[k] == pol_i[k]);
        assign edge_hit = any_i[k] ? (rise | fall) : (pol_i[k] ? rise : fall);
        assign evt_o[k] = type_i[k] ? edge_hit : lvl_hit;
    end

    // Level pins at their active level must raise an event.
    assert_level_fires_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((~type_i & ~(cur_i ^ pol_i) & ~evt_o) == '0));
    // Edge pins never fire while their synchronised input is steady.
    assert_edge_needs_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_o & type_i & ~(cur_i ^ prev_i)) == '0));
    // Any-edge pins fire on every change.
    assert_any_edge_fires_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((type_i & any_i & (cur_i ^ prev_i) & ~evt_o) == '0));
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en_i,
    input  logic [2:0]   wr_sel_i,
    input  logic [W-1:0] wr_data_i,
    input  logic [2:0]   rd_sel_i,
    input  logic [W-1:0] evt_i,
    output logic [W-1:0] rd_data_o,
    output logic [W-1:0] type_o,
    output logic [W-1:0] pol_o,
    output logic [W-1:0] any_o,
    output logic [W-1:0] live_o
);
    typedef struct packed {
        logic [W-1:0] en;
        logic [W-1:0] status;
        logic [W-1:0] typ;
        logic [W-1:0] pol;
        logic [W-1:0] any;
    } regs_t;

    regs_t        r_d, r_q;
    logic [W-1:0] clr_mask;

    always_comb begin
        r_d      = r_q;
        clr_mask = '0;
        if (wr_en_i) begin
            case (wr_sel_i)
                SEL_EN_SET: r_d.en  = r_q.en | wr_data_i;
                SEL_EN_CLR: r_d.en  = r_q.en & ~wr_data_i;
                SEL_STATUS: clr_mask = wr_data_i;
                SEL_TYPE:   r_d.typ = wr_data_i;
                SEL_POL:    r_d.pol = wr_data_i;
                SEL_ANY:    r_d.any = wr_data_i;
                default:    ;
            endcase
        end
        r_d.status = (r_q.status & ~clr_mask) | evt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (rd_sel_i)
            SEL_EN_SET, SEL_EN_CLR: rd_data_o = r_q.en;
            SEL_STATUS:             rd_data_o = r_q.status;
            SEL_TYPE:               rd_data_o = r_q.typ;
            SEL_POL:                rd_data_o = r_q.pol;
            SEL_ANY:                rd_data_o = r_q.any;
            default:                rd_data_o = '0;
        endcase
    end

    assign type_o = r_q.typ;
    assign pol_o  = r_q.pol;
    assign any_o  = r_q.any;
    assign live_o = r_q.status & r_q.en;

    assert_en_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i == SEL_EN_SET) |=> ((r_q.en & $past(wr_data_i)) == $past(wr_data_i)));
    assert_en_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i == SEL_EN_CLR) |=> ((r_q.en & $past(wr_data_i)) == '0));
    assert_status_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((r_q.status & $past(r_q.status & ~clr_mask)) == $past(r_q.status & ~clr_mask)));
    assert_event_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((r_q.status & $past(evt_i)) == $past(evt_i)));
    assert_type_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i == SEL_TYPE) |=> (r_q.typ == $past(wr_data_i)));
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int N_PINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pin_i,
    input  logic              wr_en_i,
    input  logic [2:0]        wr_sel_i,
    input  logic [N_PINS-1:0] wr_data_i,
    input  logic [2:0]        rd_sel_i,
    output logic [N_PINS-1:0] rd_data_o,
    output logic              irq_o
);
    logic [N_PINS-1:0] cur, prev, evt, cfg_type, cfg_pol, cfg_any, live;

    gpio_irq_sync #(.W(N_PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_i),
        .cur_o  (cur),
        .prev_o (prev)
    );

    gpio_irq_detect #(.W(N_PINS)) u_detect (
        .clk    (clk),
        .rst_n  (rst_n),
        .type_i (cfg_type),
        .pol_i  (cfg_pol),
        .any_i  (cfg_any),
        .cur_i  (cur),
        .prev_i (prev),
        .evt_o  (evt)
    );

    gpio_irq_regs #(.W(N_PINS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (wr_sel_i),
        .wr_data_i (wr_data_i),
        .rd_sel_i  (rd_sel_i),
        .evt_i     (evt),
        .rd_data_o (rd_data_o),
        .type_o    (cfg_type),
        .pol_o     (cfg_pol),
        .any_o     (cfg_any),
        .live_o    (live)
    );

    assign irq_o = |live;

    // Disabling every pin silences the interrupt on the next cycle.
    assert_irq_off_when_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i == SEL_EN_CLR && (&wr_data_i)) |=> !irq_o);
endmodule

// File: tb/gpio_irq_ctrl_bench.sv
module gpio_irq_ctrl_bench;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pin_i = '0;
    logic         wr_en_i = 1'b0;
    logic [2:0]   wr_sel_i = '0;
    logic [N-1:0] wr_data_i = '0;
    logic [2:0]   rd_sel_i = '0;
    logic [N-1:0] rd_data_o;
    logic         irq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpio_irq_ctrl #(.N_PINS(N)) u_gpio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .wr_en_i(wr_en_i),
        .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .rd_sel_i(rd_sel_i),
        .rd_data_o(rd_data_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] sel, output logic [N-1:0] val);
        rd_sel_i = sel;
        #1;
        val = rd_data_o;
    endtask

    // Called at a falling edge; the write lands on the next rising edge.
    task automatic wr(input logic [2:0] sel, input logic [N-1:0] data);
        wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R12 watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] v, ty, po, an, en_m, st_e;
        logic         sb, eb, act_s, act_e;
        idle(3);
        // R11: everything zero in reset
        for (int s = 0; s < 6; s++) begin
            rd(3'(s), v);
            chk("R11 reset register", 32'(v), 0);
        end
        chk("R11 reset irq", 32'(irq_o), 0);
        rst_n = 1'b1;
        idle(2);
        // R5 R11: default active-low level pins with low inputs are pending, but disabled
        rd(3'd2, v); chk("R5 R11 default pending", 32'(v), 32'hF);
        chk("R11 disabled irq", 32'(irq_o), 0);
        rd(3'd6, v); chk("R8 unused select", 32'(v), 0);
        wr(3'd7, 4'hF);
        rd(3'd0, v); chk("R8 unused write", 32'(v), 0);

        en_m = '0;
        for (int m = 0; m < 8; m++) begin
            for (int k = 0; k < N; k++) begin
                int md;
                md = (m + k) % 8;
                ty[k] = md[0]; po[k] = md[1]; an[k] = md[2];
            end
            wr(3'd3, ty); wr(3'd4, po); wr(3'd5, an);
            rd(3'd3, v); chk("R8 type readback", 32'(v), 32'(ty));
            rd(3'd4, v); chk("R8 polarity readback", 32'(v), 32'(po));
            rd(3'd5, v); chk("R8 any-edge readback", 32'(v), 32'(an));
            for (int s = 0; s < 16; s++) begin
                for (int e = 0; e < 16; e++) begin
                    pin_i = 4'(s);
                    idle(4);
                    wr(3'd2, 4'hF);
                    wr(3'd0, 4'(e));
                    wr(3'd1, 4'(s) & ~4'(e));
                    en_m = (en_m | 4'(e)) & ~(4'(s) & ~4'(e));
                    pin_i = 4'(e);
                    idle(3);
                    for (int k = 0; k < N; k++) begin
                        sb = s[k]; eb = e[k];
                        act_s = (sb == po[k]); act_e = (eb == po[k]);
                        if (!ty[k]) st_e[k] = act_s | act_e;
                        else if (an[k]) st_e[k] = sb ^ eb;
                        else st_e[k] = po[k] ? (!sb & eb) : (sb & !eb);
                    end
                    rd(3'd2, v); chk("R4 R5 R6 R7 pending", 32'(v), 32'(st_e));
                    rd(3'd1, v); chk("R1 R2 R3 enable", 32'(v), 32'(en_m));
                    chk("R10 irq", 32'(irq_o), 32'(|(st_e & en_m)));
                end
            end
        end

        // Directed: rising-edge pins, collision of event and clear
        wr(3'd1, 4'hF);
        wr(3'd3, 4'hF); wr(3'd4, 4'hF); wr(3'd5, 4'h0);
        pin_i = 4'h0;
        idle(4);
        wr(3'd2, 4'hF);
        pin_i = 4'h1;
        idle(2);
        rd(3'd2, v); chk("R12 not yet visible", 32'(v), 0);
        wr(3'd2, 4'h1);
        rd(3'd2, v); chk("R9 event beats clear", 32'(v), 32'h1);
        wr(3'd2, 4'h1);
        rd(3'd2, v); chk("R4 edge bit cleared", 32'(v), 0);
        wr(3'd0, 4'h1);
        pin_i = 4'h0;
        idle(4);
        rd(3'd2, v); chk("R6 falling ignored", 32'(v), 0);
        chk("R10 no pending", 32'(irq_o), 0);
        pin_i = 4'h1;
        idle(3);
        rd(3'd2, v); chk("R12 visible third edge", 32'(v), 32'h1);
        chk("R10 irq raised", 32'(irq_o), 1);
        wr(3'd1, 4'h1);
        chk("R2 R10 irq dropped", 32'(irq_o), 0);
        rd(3'd2, v); chk("R4 still pending", 32'(v), 32'h1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule